// File: doc/BRIEF.md
# Threshold-Qualified Event Counter

This block is a performance-monitor counter. An event source supplies a small count each cycle, and that count can be more than one. The counter adds to a wide accumulator only on cycles where the count passes a programmable test. The test compares the count against a programmed threshold, and a two-bit selector chooses the kind of comparison. A mode flag decides what a passing cycle adds: either the whole count for that cycle, or exactly one. Counting in units of one turns the counter into a tally of qualifying cycles.

A threshold of zero switches the test off. The counter then adds the raw count every cycle. Zero is needed as the "off" value because zero is also a legal value for both the selector and the mode flag. Software can preload the accumulator through a write port and can clear it. A sticky flag records that the accumulator has wrapped.

Top module: `thr_evt_counter`

## Requirements
- R11: After reset the count output is 0 and the overflow flag is 0.
- R1: With a nonzero threshold, the accumulator advances on a cycle only when that cycle's event count satisfies the selected comparison against the threshold. Otherwise it adds 0.
- R2: The comparison selector encodes 0 = not equal, 1 = equal, 2 = greater than or equal, and 3 = less than. The event count is zero-extended before being compared with the threshold as an unsigned number, so a threshold wider than the event count is never truncated.
- R3: With the mode flag at 0, a passing cycle adds the full event count of that cycle.
- R4: With the mode flag at 1, a passing cycle adds exactly 1, whatever the event count.
- R5: A threshold of 0 disables qualification. Every enabled cycle then adds the raw event count, whatever the selector and mode flag hold.
- R6: The threshold, selector and mode flag are registered. A change applied in one cycle first affects the comparison of the following cycle.
- R7: While the enable is low and no write or clear is present, the accumulator keeps its value.
- R8: A write loads the write data into the accumulator, whatever the enable is. The write wins over an increment in the same cycle and leaves the overflow flag unchanged.
- R9: An increment that carries out of the top of the accumulator wraps it and sets the overflow flag. The flag then stays set until a clear. Reaching exactly the maximum value does not set the flag.
- R10: A clear sets the accumulator and the overflow flag to 0. It takes priority over a write and over an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Counting enable |
| clr | input | 1 | Synchronous clear of accumulator and overflow flag |
| wr_en | input | 1 | Software write strobe for preloading the accumulator |
| wr_data | input | CNT_W | Value loaded on a write |
| evt_cnt | input | EVT_W | Number of events seen this cycle |
| cfg_thr | input | THR_W | Threshold value; 0 disables qualification |
| cfg_cmp | input | 2 | Comparison selector (0 ne, 1 eq, 2 ge, 3 lt) |
| cfg_one | input | 1 | 1: add one per passing cycle; 0: add the full count |
| count | output | CNT_W | Accumulator value |
| ovf | output | 1 | Sticky wrap flag |

## Verification
The bench keeps the default 4-bit event count and 12-bit threshold, so thresholds above 15 can be applied. Those thresholds expose any comparison that truncates the threshold instead of zero-extending the event count. It narrows the accumulator to 16 bits. At that width the wrap boundary is only a preload away: the exact maximum with no flag, the carry-out that sets the flag, and the stickiness that follows. All of this fits in a few cycles while exercising the same add-with-carry logic as the 64-bit default.

// File: rtl/thr_evt_pkg.sv
package thr_evt_pkg;
    typedef enum logic [1:0] {
        CMP_NE = 2'd0,
        CMP_EQ = 2'd1,
        CMP_GE = 2'd2,
        CMP_LT = 2'd3
    } cmp_e;
endpackage

// File: rtl/thr_evt_cfg.sv
module thr_evt_cfg
    import thr_evt_pkg::*;
#(
    parameter int THR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [THR_W-1:0] thr_i,
    input  logic [1:0]       cmp_i,
    input  logic             one_i,
    output logic [THR_W-1:0] thr_o,
    output cmp_e             cmp_o,
    output logic             one_o
);
    typedef struct packed {
        logic [THR_W-1:0] thr;
        cmp_e             cmp;
        logic             one;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d.thr = thr_i;
        cfg_d.cmp = cmp_e'(cmp_i);
        cfg_d.one = one_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{thr: '0, cmp: CMP_NE, one: 1'b0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign thr_o = cfg_q.thr;
    assign cmp_o = cfg_q.cmp;
    assign one_o = cfg_q.one;
endmodule

// File: rtl/thr_evt_qual.sv
module thr_evt_qual
    import thr_evt_pkg::*;
#(
    parameter int EVT_W = 4,
    parameter int THR_W = 12
) (
    input  logic [EVT_W-1:0] evt_i,
    input  logic [THR_W-1:0] thr_i,
    input  cmp_e             cmp_i,
    input  logic             one_i,
    output logic [EVT_W-1:0] inc_o
);
    localparam int CMP_W = (THR_W > EVT_W) ? THR_W : EVT_W;

    logic [CMP_W-1:0] evt_x;
    logic [CMP_W-1:0] thr_x;
    logic             pass;
    logic             bypass;

    // Both operands are widened to the larger width, so neither is ever truncated.
    assign evt_x  = CMP_W'(evt_i);
    assign thr_x  = CMP_W'(thr_i);
    assign bypass = (thr_i == '0);

    always_comb begin
        unique case (cmp_i)
            CMP_NE:  pass = (evt_x != thr_x);
            CMP_EQ:  pass = (evt_x == thr_x);
            CMP_GE:  pass = (evt_x >= thr_x);
            CMP_LT:  pass = (evt_x <  thr_x);
            default: pass = 1'b0;
        endcase
    end

    always_comb begin
        if (bypass) begin
            inc_o = evt_i;
        end else if (!pass) begin
            inc_o = '0;
        end else if (one_i) begin
            inc_o = EVT_W'(1);
        end else begin
            inc_o = evt_i;
        end
    end
endmodule

// File: rtl/thr_evt_accum.sv
module thr_evt_accum #(
    parameter int EVT_W = 4,
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             clr_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic [EVT_W-1:0] inc_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             ovf;
    } acc_t;

    acc_t         acc_d, acc_q;
    logic [CNT_W:0] sum;

    assign sum = {1'b0, acc_q.count} + (CNT_W+1)'(inc_i);

    always_comb begin
        acc_d = acc_q;
        if (clr_i) begin
            acc_d.count = '0;
            acc_d.ovf   = 1'b0;
        end else if (wr_i) begin
            acc_d.count = wr_data_i;
        end else if (en_i) begin
            acc_d.count = sum[CNT_W-1:0];
            acc_d.ovf   = acc_q.ovf | sum[CNT_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '{count: '0, ovf: 1'b0};
        end else begin
            acc_q <= acc_d;
        end
    end

    assign count_o = acc_q.count;
    assign ovf_o   = acc_q.ovf;
endmodule

// File: rtl/thr_evt_counter.sv
module thr_evt_counter
    import thr_evt_pkg::*;
#(
    parameter int EVT_W = 4,
    parameter int THR_W = 12,
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [EVT_W-1:0] evt_cnt,
    input  logic [THR_W-1:0] cfg_thr,
    input  logic [1:0]       cfg_cmp,
    input  logic             cfg_one,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    logic [THR_W-1:0] cfg_thr_q;
    cmp_e             cfg_cmp_q;
    logic             cfg_one_q;
    logic [EVT_W-1:0] inc;

    thr_evt_cfg #(.THR_W(THR_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .thr_i (cfg_thr),
        .cmp_i (cfg_cmp),
        .one_i (cfg_one),
        .thr_o (cfg_thr_q),
        .cmp_o (cfg_cmp_q),
        .one_o (cfg_one_q)
    );

    thr_evt_qual #(.EVT_W(EVT_W), .THR_W(THR_W)) u_qual (
        .evt_i (evt_cnt),
        .thr_i (cfg_thr_q),
        .cmp_i (cfg_cmp_q),
        .one_i (cfg_one_q),
        .inc_o (inc)
    );

    thr_evt_accum #(.EVT_W(EVT_W), .CNT_W(CNT_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en),
        .clr_i     (clr),
        .wr_i      (wr_en),
        .wr_data_i (wr_data),
        .inc_i     (inc),
        .count_o   (count),
        .ovf_o     (ovf)
    );
endmodule

// File: rtl/thr_evt_counter_chk.sv
module thr_evt_counter_chk #(
    parameter int EVT_W = 4,
    parameter int THR_W = 12,
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             clr,
    input logic             wr_en,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] count,
    input logic             ovf,
    input logic [THR_W-1:0] cfg_thr_q,
    input logic             cfg_one_q
);
    localparam logic [CNT_W-1:0] STEP_MAX = CNT_W'((1 << EVT_W) - 1);

    // R7: with no enable, write or clear, the value holds
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !wr_en && !en) |=> (count == $past(count)));

    // R8: a write loads the data and leaves the flag alone
    p_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && wr_en) |=> (count == $past(wr_data) && ovf == $past(ovf)));

    // R10: a clear zeroes both
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0 && !ovf));

    // R9: the flag is sticky until a clear
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf);

    // R9: the flag rises only on a wrap caused by an increment
    p_rise_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> ($past(!clr && !wr_en && en) && count < $past(count)));

    // R1: one enabled cycle adds no more than the largest event count
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !wr_en && en) |=> ((count - $past(count)) <= STEP_MAX));

    // R4: in one-per-cycle mode with a nonzero threshold, the step is 0 or 1
    p_unit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !wr_en && en && cfg_one_q && cfg_thr_q != '0)
        |=> ((count - $past(count)) <= CNT_W'(1)));
endmodule

bind thr_evt_counter thr_evt_counter_chk #(
    .EVT_W(EVT_W), .THR_W(THR_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/thr_evt_counter_tb.sv
module thr_evt_counter_tb;
    localparam int EVT_W = 4;
    localparam int THR_W = 12;
    localparam int CNT_W = 16;
    localparam int NVEC  = 15;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic             clr = 1'b0;
    logic             wr_en = 1'b0;
    logic [CNT_W-1:0] wr_data = '0;
    logic [EVT_W-1:0] evt_cnt = '0;
    logic [THR_W-1:0] cfg_thr = '0;
    logic [1:0]       cfg_cmp = '0;
    logic             cfg_one = 1'b0;
    logic [CNT_W-1:0] count;
    logic             ovf;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    thr_evt_counter #(.EVT_W(EVT_W), .THR_W(THR_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .wr_en(wr_en),
        .wr_data(wr_data), .evt_cnt(evt_cnt), .cfg_thr(cfg_thr),
        .cfg_cmp(cfg_cmp), .cfg_one(cfg_one), .count(count), .ovf(ovf)
    );

    // {thr[26:15], cmp[14:13], one[12], evt[11:8], expected increment[7:0]}
    localparam logic [26:0] VEC [NVEC] = '{
        {12'd2,   2'd2, 1'b0, 4'd3,  8'd3},   // R3 ge pass
        {12'd2,   2'd2, 1'b0, 4'd1,  8'd0},   // R1 ge fail
        {12'd2,   2'd2, 1'b0, 4'd2,  8'd2},   // R2 ge boundary
        {12'd2,   2'd2, 1'b1, 4'd7,  8'd1},   // R4 unit mode
        {12'd5,   2'd1, 1'b0, 4'd5,  8'd5},   // R2 eq pass
        {12'd5,   2'd1, 1'b0, 4'd4,  8'd0},   // R2 eq fail
        {12'd5,   2'd0, 1'b0, 4'd4,  8'd4},   // R2 ne pass
        {12'd5,   2'd0, 1'b0, 4'd5,  8'd0},   // R2 ne fail
        {12'd5,   2'd3, 1'b1, 4'd4,  8'd1},   // R4 lt pass unit
        {12'd5,   2'd3, 1'b0, 4'd5,  8'd0},   // R2 lt fail
        {12'd0,   2'd1, 1'b1, 4'd9,  8'd9},   // R5 bypass ignores eq/unit
        {12'd0,   2'd0, 1'b1, 4'd15, 8'd15},  // R5 bypass ignores ne/unit
        {12'd100, 2'd3, 1'b0, 4'd15, 8'd15},  // R2 wide threshold lt
        {12'd16,  2'd2, 1'b0, 4'd15, 8'd0},   // R2 no truncation of threshold
        {12'd16,  2'd0, 1'b1, 4'd0,  8'd1}    // R4 ne with zero events
    };

    task automatic check(input string req, input logic [CNT_W-1:0] act,
                         input logic [CNT_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [CNT_W-1:0] prev;
        repeat (3) @(negedge clk);
        check("R11 count", count, '0);
        check("R11 ovf", {15'd0, ovf}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            cfg_thr = VEC[i][26:15];
            cfg_cmp = VEC[i][14:13];
            cfg_one = VEC[i][12];
            en      = 1'b0;
            evt_cnt = '0;
            @(negedge clk);
            prev    = count;
            en      = 1'b1;
            evt_cnt = VEC[i][11:8];
            @(negedge clk);
            check($sformatf("R1/R2 vector %0d", i), count,
                  prev + CNT_W'(VEC[i][7:0]));
            en = 1'b0;
        end

        // R6: config applied with the events still uses the old settings
        cfg_thr = 12'd2; cfg_cmp = 2'd2; cfg_one = 1'b0; en = 1'b0;
        @(negedge clk);
        prev = count;
        cfg_cmp = 2'd1; en = 1'b1; evt_cnt = 4'd3;
        @(negedge clk);
        check("R6 old compare in effect", count, prev + 16'd3);
        prev = count;
        @(negedge clk);
        check("R6 new compare in effect", count, prev);

        // R7: enable low holds
        cfg_thr = '0; en = 1'b0; evt_cnt = 4'd5;
        @(negedge clk);
        prev = count;
        @(negedge clk);
        @(negedge clk);
        check("R7 hold", count, prev);

        // R8: write beats increment
        en = 1'b1; wr_en = 1'b1; wr_data = 16'h1234;
        @(negedge clk);
        check("R8 write priority", count, 16'h1234);
        check("R8 ovf untouched", {15'd0, ovf}, '0);

        // R8: write with enable low; R9 exact max
        en = 1'b0; wr_data = 16'hFFFC;
        @(negedge clk);
        check("R8 write without enable", count, 16'hFFFC);
        wr_en = 1'b0; en = 1'b1; evt_cnt = 4'd3;
        @(negedge clk);
        check("R9 exact max", count, 16'hFFFF);
        check("R9 no flag at max", {15'd0, ovf}, '0);
        @(negedge clk);
        check("R9 wrap value", count, 16'h0002);
        check("R9 flag set", {15'd0, ovf}, 16'd1);
        evt_cnt = 4'd1;
        @(negedge clk);
        check("R9 sticky flag", {15'd0, ovf}, 16'd1);
        check("R9 counting continues", count, 16'h0003);
        en = 1'b0; wr_en = 1'b1; wr_data = 16'h0010;
        @(negedge clk);
        check("R8 write keeps flag", {15'd0, ovf}, 16'd1);

        // R10: clear beats write and increment
        clr = 1'b1; wr_data = 16'h0055; en = 1'b1; evt_cnt = 4'd5;
        @(negedge clk);
        check("R10 clear count", count, '0);
        check("R10 clear flag", {15'd0, ovf}, '0);
        clr = 1'b0; wr_en = 1'b0; en = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule